// File: doc/BRIEF.md
# Turbo-Aware Performance Level Governor

This block decides which performance level a processor core actually runs at. Software writes a requested level. Level 0 is the highest turbo frequency. Level 1 is the guaranteed frequency. Each higher number is a slower point, down to the slowest level `PN_LVL`, which is the most energy-efficient operating point. A request for any non-turbo level is passed straight through as the target. A request for level 0 is different: software only states that it wants turbo. Hardware then chooses between level 0 and level 1 from an energy budget.

The energy budget is a saturating accumulator that moves every clock cycle. It rises by the margin between the sustained power limit and the measured power sample, and it falls by the same margin when the sample is above the limit. It is held between zero and a programmable ceiling. Turbo is entered only when the budget is above a programmable threshold. Turbo is left when the budget runs dry. Under steady heavy load the core therefore returns to the guaranteed level, and power settles at the sustained limit.

Every level change goes through a request/acknowledge handshake with the clock and voltage logic. After a change has been acknowledged, the block waits a programmable update interval before it may start another change.

Top module: `pstate_turbo_ctl`

## Requirements
- R1: While reset is held, and after its release, `grant_lvl` is `PN_LVL`, `budget` is 0 and `chg_req` is 0.
- R2: On every clock, `budget` becomes the previous budget plus `tdp` minus `pwr_smp`. The result is clipped below at 0 and above at the `bud_max` value present at that edge.
- R3: When the requested level is nonzero, the target is that level, clamped to `PN_LVL` if the request is numerically above it. The budget is not consulted.
- R4: When level 0 is requested and the granted level is numerically greater than 1, the target is 1, the guaranteed level.
- R5: When level 0 is requested and the granted level is 1, the target is 0 only if `budget` is strictly greater than `bud_thr`. Otherwise the level stays at 1.
- R6: When level 0 is granted and `budget` is 0, the target becomes 1.
- R7: A change is raised by setting `chg_req` with the target on `tgt_lvl`. Both hold steady until `ack` is seen high while `chg_req` is high. `grant_lvl` takes `tgt_lvl` on that edge and changes at no other time. `ack` while `chg_req` is low has no effect.
- R8: After an acknowledged change, `chg_req` is not raised again until `upd_int` clock edges have passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_lvl | input | LVL_W | Software-requested level (0 = turbo) |
| pwr_smp | input | PWR_W | Power sample for this cycle |
| tdp | input | PWR_W | Sustained power limit |
| bud_max | input | BUD_W | Budget ceiling |
| bud_thr | input | BUD_W | Budget needed before entering turbo |
| upd_int | input | INT_W | Minimum cycles between level changes |
| ack | input | 1 | Change acknowledge from the clock/voltage logic |
| chg_req | output | 1 | Level change pending |
| tgt_lvl | output | LVL_W | Level being requested |
| grant_lvl | output | LVL_W | Level currently in force |
| budget | output | BUD_W | Current energy budget |

## Verification
The bench targets the following corner cases, each paired with the failure it would expose:

- **Budget saturation.** The budget is driven into both rails, and the ceiling is then lowered below the current budget. A design with a wrapping accumulator would show a huge budget after draining, or a tiny one after filling.
- **Turbo entry.** Turbo is requested with the budget both below and above the threshold. An off-by-one compare, or an entry made without budget, would show up as an early or unpaid step to level 0.
- **Forced exit on an empty budget.** Power is held above the limit until the budget empties. This forces the return to the guaranteed level.
- **Request clamping.** Out-of-range slow requests check the clamp to the slowest level.
- **Acknowledge withheld.** The acknowledge is held off for many cycles. A design that commits without it, or that lets its target drift, would be caught.
- **Long update interval.** A design that ignores the interval would raise a new change too early.

// File: rtl/pstate_turbo_ctl.sv
module pstate_turbo_ctl #(
  parameter int LVL_W  = 4,
  parameter int PWR_W  = 8,
  parameter int BUD_W  = 12,
  parameter int INT_W  = 6,
  parameter int PN_LVL = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] req_lvl,
  input  logic [PWR_W-1:0] pwr_smp,
  input  logic [PWR_W-1:0] tdp,
  input  logic [BUD_W-1:0] bud_max,
  input  logic [BUD_W-1:0] bud_thr,
  input  logic [INT_W-1:0] upd_int,
  input  logic             ack,
  output logic             chg_req,
  output logic [LVL_W-1:0] tgt_lvl,
  output logic [LVL_W-1:0] grant_lvl,
  output logic [BUD_W-1:0] budget
);

  localparam int SW = BUD_W + 2;
  localparam logic [LVL_W-1:0] PN    = LVL_W'(PN_LVL);
  localparam logic [LVL_W-1:0] GUAR  = LVL_W'(1);
  localparam logic [LVL_W-1:0] TURBO = '0;

  logic signed [SW-1:0] bud_sum;
  logic [BUD_W-1:0]     bud_nxt;
  logic [LVL_W-1:0]     eff_req;
  logic [LVL_W-1:0]     want;
  logic [INT_W-1:0]     tmr;
  logic                 commit;
  logic                 raise;

  assign bud_sum = $signed({2'b00, budget})
                 + $signed({{(SW-PWR_W){1'b0}}, tdp})
                 - $signed({{(SW-PWR_W){1'b0}}, pwr_smp});

  always_comb begin
    if (bud_sum < 0)
      bud_nxt = '0;
    else if (bud_sum > $signed({2'b00, bud_max}))
      bud_nxt = bud_max;
    else
      bud_nxt = bud_sum[BUD_W-1:0];
  end

  assign eff_req = (req_lvl > PN) ? PN : req_lvl;

  always_comb begin
    if (eff_req != TURBO)
      want = eff_req;
    else if (grant_lvl == TURBO)
      want = (budget == '0) ? GUAR : TURBO;
    else if (grant_lvl == GUAR)
      want = (budget > bud_thr) ? TURBO : GUAR;
    else
      want = GUAR;
  end

  assign commit = chg_req && ack;
  assign raise  = !chg_req && (tmr == '0) && (want != grant_lvl);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      budget    <= '0;
      grant_lvl <= PN;
      tgt_lvl   <= PN;
      chg_req   <= 1'b0;
      tmr       <= '0;
    end else begin
      budget <= bud_nxt;
      if (commit) begin
        grant_lvl <= tgt_lvl;
        chg_req   <= 1'b0;
        tmr       <= upd_int;
      end else begin
        if (tmr != '0) tmr <= tmr - 1'b1;
        if (raise) begin
          chg_req <= 1'b1;
          tgt_lvl <= want;
        end
      end
    end
  end

endmodule

// File: rtl/pstate_turbo_chk.sv
module pstate_turbo_chk #(
  parameter int LVL_W  = 4,
  parameter int BUD_W  = 12,
  parameter int INT_W  = 6,
  parameter int PN_LVL = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack,
  input logic             chg_req,
  input logic [LVL_W-1:0] tgt_lvl,
  input logic [LVL_W-1:0] grant_lvl,
  input logic [BUD_W-1:0] budget,
  input logic [BUD_W-1:0] bud_max,
  input logic [BUD_W-1:0] bud_thr,
  input logic [INT_W-1:0] tmr
);

  a_r2_budget_cap: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> budget <= $past(bud_max));

  a_r3_grant_range: assert property (@(posedge clk) disable iff (!rst_n)
    grant_lvl <= LVL_W'(PN_LVL));

  a_r5_turbo_paid: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(chg_req) && tgt_lvl == '0) |-> $past(budget) > $past(bud_thr));

  a_r7_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_req && !ack) |=> (chg_req && $stable(tgt_lvl)));

  a_r7_grant_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(chg_req && ack) |=> $stable(grant_lvl));

  a_r7_grant_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_req && ack) |=> (grant_lvl == $past(tgt_lvl) && !chg_req));

  a_r8_interval: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chg_req) |-> $past(tmr) == '0);

endmodule

bind pstate_turbo_ctl pstate_turbo_chk #(
  .LVL_W(LVL_W), .BUD_W(BUD_W), .INT_W(INT_W), .PN_LVL(PN_LVL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .chg_req(chg_req),
  .tgt_lvl(tgt_lvl), .grant_lvl(grant_lvl), .budget(budget),
  .bud_max(bud_max), .bud_thr(bud_thr), .tmr(tmr)
);

// File: tb/pstate_turbo_ctl_tb.sv
module pstate_turbo_ctl_tb;
  localparam int LVL_W = 4, PWR_W = 8, BUD_W = 12, INT_W = 6, PN_LVL = 7;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [LVL_W-1:0] req_lvl = '0;
  logic [PWR_W-1:0] pwr_smp = '0;
  logic [PWR_W-1:0] tdp = 8'd50;
  logic [BUD_W-1:0] bud_max = 12'd400;
  logic [BUD_W-1:0] bud_thr = 12'd100;
  logic [INT_W-1:0] upd_int = 6'd4;
  logic             ack = 1'b0;
  logic             chg_req;
  logic [LVL_W-1:0] tgt_lvl, grant_lvl;
  logic [BUD_W-1:0] budget;

  always #10 clk = ~clk;

  pstate_turbo_ctl #(.LVL_W(LVL_W), .PWR_W(PWR_W), .BUD_W(BUD_W),
                     .INT_W(INT_W), .PN_LVL(PN_LVL)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_lvl(req_lvl), .pwr_smp(pwr_smp),
    .tdp(tdp), .bud_max(bud_max), .bud_thr(bud_thr), .upd_int(upd_int),
    .ack(ack), .chg_req(chg_req), .tgt_lvl(tgt_lvl),
    .grant_lvl(grant_lvl), .budget(budget));

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int ack_mode = 1;
  logic [7:0] lfsr = 8'hA5;

  int m_bud, m_grant, m_tgt, m_chg, m_cnt;
  string m_why;

  always @(posedge clk) begin
    int nb, eff, want, old_cnt;
    if (!rst_n) begin
      m_bud = 0; m_grant = PN_LVL; m_tgt = PN_LVL; m_chg = 0; m_cnt = 0;
      m_why = "R1";
    end else begin
      nb = m_bud + int'(tdp) - int'(pwr_smp);
      if (nb < 0) nb = 0;
      if (nb > int'(bud_max)) nb = int'(bud_max);
      eff = (int'(req_lvl) > PN_LVL) ? PN_LVL : int'(req_lvl);
      if (eff != 0) want = eff;
      else if (m_grant == 0) want = (m_bud == 0) ? 1 : 0;
      else if (m_grant == 1) want = (m_bud > int'(bud_thr)) ? 0 : 1;
      else want = 1;
      old_cnt = m_cnt;
      if (m_chg == 1 && ack) begin
        m_grant = m_tgt; m_chg = 0; m_cnt = int'(upd_int);
      end else begin
        if (m_cnt > 0) m_cnt = m_cnt - 1;
        if (m_chg == 0 && old_cnt == 0 && want != m_grant) begin
          m_chg = 1; m_tgt = want;
          if (eff != 0) m_why = "R3";
          else if (want == 0) m_why = "R5";
          else if (m_grant == 0) m_why = "R6";
          else m_why = "R4";
        end
      end
      m_bud = nb;
    end
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 budget", int'(budget), m_bud);
      chk({m_why, " chg_req"}, int'(chg_req), m_chg);
      if (m_chg == 1) chk({m_why, " tgt_lvl"}, int'(tgt_lvl), m_tgt);
      chk("R7 grant_lvl", int'(grant_lvl), m_grant);
    end
    case (ack_mode)
      0: ack <= 1'b0;
      1: ack <= lfsr[0];
      default: ack <= 1'b1;
    endcase
  end

  task automatic run(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    run(3);
    chk("R1 grant in reset", int'(grant_lvl), PN_LVL);
    chk("R1 budget in reset", int'(budget), 0);
    chk("R1 chg_req in reset", int'(chg_req), 0);
    rst_n = 1'b1;
    req_lvl = 4'd7; pwr_smp = 8'd80;
    run(1);
    chk("R1 grant after reset", int'(grant_lvl), PN_LVL);
    run(10);
    chk("R2 budget floor", int'(budget), 0);
    req_lvl = 4'd5; pwr_smp = 8'd30;
    run(40);
    chk("R3 direct grant", int'(grant_lvl), 5);
    req_lvl = 4'd12;
    run(30);
    chk("R3 clamp to slowest", int'(grant_lvl), PN_LVL);
    req_lvl = 4'd0; pwr_smp = 8'd20;
    run(60);
    chk("R2 budget ceiling", int'(budget), 400);
    chk("R5 turbo entered", int'(grant_lvl), 0);
    pwr_smp = 8'd90;
    run(40);
    chk("R2 budget drained", int'(budget), 0);
    chk("R6 turbo exit", int'(grant_lvl), 1);
    pwr_smp = 8'd50;
    run(30);
    chk("R5 no budget no turbo", int'(grant_lvl), 1);
    chk("R4 guaranteed held", int'(chg_req), 0);
    ack_mode = 0; req_lvl = 4'd3;
    run(25);
    chk("R7 request held", int'(chg_req), 1);
    chk("R7 target held", int'(tgt_lvl), 3);
    chk("R7 grant waits for ack", int'(grant_lvl), 1);
    ack_mode = 1;
    run(20);
    chk("R7 grant after ack", int'(grant_lvl), 3);
    ack_mode = 2; upd_int = 6'd30; req_lvl = 4'd5;
    run(40);
    chk("R8 setup grant", int'(grant_lvl), 5);
    req_lvl = 4'd6;
    while (grant_lvl != 4'd6) @(negedge clk);
    req_lvl = 4'd2;
    for (int i = 0; i < 25; i++) begin
      chk("R8 interval quiet", int'(chg_req), 0);
      @(negedge clk);
    end
    run(15);
    chk("R8 change after interval", int'(grant_lvl), 2);
    ack_mode = 1; upd_int = 6'd2; req_lvl = 4'd0; pwr_smp = 8'd0;
    run(40);
    chk("R2 ceiling reached", int'(budget), 400);
    bud_max = 12'd150;
    run(2);
    chk("R2 lowered ceiling", int'(budget), 150);
    run(5);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule